// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Per-Pin Interrupts

This block is an eight-pin general purpose I/O port that sits on a simple byte-wide register bus. Each pin can be set as an input or an output. Pin data is reached through a window of addresses in which address bits pick the pins touched by an access, so software can change or sample any subset of pins in one access without a read-modify-write.

Every pin also feeds its own interrupt detector. The detector can sense a level or an edge, with a polarity choice, and can also fire on both edges. Edge events are latched until software clears them by writing ones. An enable mask gates the raw status into a masked status, and the OR of the masked bits drives one interrupt line. Pin inputs pass through a two-flop synchroniser before any logic sees them. Bus reads are combinational from the address; writes take effect on the clock edge that samples the write strobe.

Top module: `gpio8_irq`

## Requirements
- R1: After reset every register reads 0x00, all pins are inputs (`pin_oe` = 0x00), `pin_out` = 0x00 and `irq_out` = 0.
- R2: Byte offset 0x400 holds the direction bits; bit n = 1 makes pin n an output and `pin_oe[n]` follows the written value from the next cycle.
- R3: Byte offsets 0x000 to 0x3FC form the data window; address bits [9:2] are a pin mask (pin n at offset 1 << (n+2)) and a write changes the output value only of pins that are both masked and outputs.
- R4: A data write to a pin that is an input leaves its output value unchanged, so switching the pin to output later shows the old value until it is written again.
- R5: A data window read returns, for each masked pin, the driven value for an output pin or the synchronised input for an input pin; unmasked bits read 0.
- R6: Offset 0x404 bit n = 1 selects level sensing; offset 0x40C bit n = 1 means high level, 0 low level; level status follows the synchronised input, is not latched and ignores clear writes.
- R7: With sense bit 0 and both-edges bit 0, event bit 1 latches on a rising edge only and event bit 0 on a falling edge only.
- R8: Offset 0x408 bit n = 1 with edge sensing latches on both rising and falling edges, whatever the event bit.
- R9: Raw status reads at 0x414, masked status at 0x418 is raw AND the enable bits at 0x410, and `irq_out` is 1 exactly when masked status is nonzero.
- R10: Writing 1s to offset 0x41C clears the matching latched edge bits, 0s have no effect, and an edge detected in the same cycle as the clear leaves the bit set.
- R11: Sense, both-edges, event and enable registers read back what was written; the clear offset reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 11 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address |
| pin_in | input | 8 | Pin input levels, asynchronous |
| pin_out | output | 8 | Output values to the pad drivers |
| pin_oe | output | 8 | Output enables (1 = drive) |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is an edge that is detected in the very cycle a clear write for the same bit lands, since the edge appears three clock edges after the pin moves. The stimulus changes the pin at a falling clock edge, counts two rising edges through the synchroniser, then drives the clear so that it is sampled on the same edge that latches the new event, and checks that the status bit stays set. Each sensing mode is also walked through both polarities and the opposite edge to show it is ignored.

// File: rtl/gpio8_pkg.sv
package gpio8_pkg;

  localparam int NPINS       = 8;
  localparam int SYNC_STAGES = 2;

  // Selector taken from address bits [4:2] in the configuration region.
  typedef enum logic [2:0] {
    SEL_DIR   = 3'd0,
    SEL_SENSE = 3'd1,
    SEL_BOTH  = 3'd2,
    SEL_EVENT = 3'd3,
    SEL_EN    = 3'd4,
    SEL_RAW   = 3'd5,
    SEL_MASK  = 3'd6,
    SEL_CLR   = 3'd7
  } cfg_sel_e;

endpackage

// File: rtl/gpio8_rst_sync.sv
module gpio8_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_core_n = stage_q[1];

endmodule

// File: rtl/gpio8_in_sync.sv
module gpio8_in_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [STAGES-1:0][WIDTH-1:0] chain_d;

  always_comb begin
    chain_d[0] = async_in;
    for (int s = 1; s < STAGES; s++) begin
      chain_d[s] = chain_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/gpio8_irq_pin.sv
module gpio8_irq_pin (
  input  logic clk,
  input  logic rst_n,
  input  logic smp,
  input  logic sense_lvl,
  input  logic both_edge,
  input  logic event_pol,
  input  logic clr,
  output logic raw
);

  logic prev_q;
  logic latch_q;
  logic latch_d;
  logic rise;
  logic fall;
  logic edge_hit;
  logic edge_set;
  logic lvl_match;

  always_comb begin
    rise      = smp & ~prev_q;
    fall      = ~smp & prev_q;
    if (both_edge) begin
      edge_hit = rise | fall;
    end else if (event_pol) begin
      edge_hit = rise;
    end else begin
      edge_hit = fall;
    end
    edge_set  = ~sense_lvl & edge_hit;
    latch_d   = edge_set | (latch_q & ~clr);
    lvl_match = event_pol ? smp : ~smp;
    raw       = sense_lvl ? lvl_match : latch_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q  <= smp;
      latch_q <= latch_d;
    end
  end

  // R10
  clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sense_lvl && clr && !edge_hit) |=> (sense_lvl || !raw));

  // R10
  edge_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sense_lvl && clr && edge_hit) |=> (sense_lvl || raw));

  // R8
  dual_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sense_lvl && both_edge && (smp != prev_q)) |=> (sense_lvl || raw));

  // R7
  single_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sense_lvl && !both_edge && event_pol && $rose(smp) && !clr && !raw)
      |=> (sense_lvl || raw || clr));

endmodule

// File: rtl/gpio8_regs.sv
module gpio8_regs
  import gpio8_pkg::*;
#(
  parameter int NP     = 8,
  parameter int ADDR_W = NP + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [NP-1:0]     bus_wdata,
  input  logic [NP-1:0]     pin_sync,
  input  logic [NP-1:0]     raw_st,
  output logic [NP-1:0]     dir_q,
  output logic [NP-1:0]     sense_q,
  output logic [NP-1:0]     both_q,
  output logic [NP-1:0]     event_q,
  output logic [NP-1:0]     en_q,
  output logic [NP-1:0]     out_q,
  output logic [NP-1:0]     clr_pulse,
  output logic [NP-1:0]     bus_rdata
);

  localparam int REGION_BIT = NP + 2;

  logic          win_hit;
  logic          cfg_hit;
  logic [NP-1:0] pin_mask;
  cfg_sel_e      sel;
  logic          dir_we;
  logic          sense_we;
  logic          both_we;
  logic          event_we;
  logic          en_we;
  logic          out_we;
  logic [NP-1:0] wr_bits;
  logic [NP-1:0] out_d;
  logic [NP-1:0] win_view;

  // Address decode
  always_comb begin
    pin_mask = bus_addr[REGION_BIT-1:2];
    win_hit  = ~bus_addr[REGION_BIT];
    cfg_hit  = bus_addr[REGION_BIT] && (bus_addr[REGION_BIT-1:5] == '0)
               && (bus_addr[1:0] == 2'b00);
    sel      = cfg_sel_e'(bus_addr[4:2]);
  end

  // Next-state and write enables
  always_comb begin
    dir_we    = bus_wr && cfg_hit && (sel == SEL_DIR);
    sense_we  = bus_wr && cfg_hit && (sel == SEL_SENSE);
    both_we   = bus_wr && cfg_hit && (sel == SEL_BOTH);
    event_we  = bus_wr && cfg_hit && (sel == SEL_EVENT);
    en_we     = bus_wr && cfg_hit && (sel == SEL_EN);
    out_we    = bus_wr && win_hit;
    wr_bits   = pin_mask & dir_q;
    out_d     = (out_q & ~wr_bits) | (bus_wdata & wr_bits);
    clr_pulse = (bus_wr && cfg_hit && (sel == SEL_CLR)) ? bus_wdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      sense_q <= '0;
      both_q  <= '0;
      event_q <= '0;
      en_q    <= '0;
      out_q   <= '0;
    end else begin
      if (dir_we)   dir_q   <= bus_wdata;
      if (sense_we) sense_q <= bus_wdata;
      if (both_we)  both_q  <= bus_wdata;
      if (event_we) event_q <= bus_wdata;
      if (en_we)    en_q    <= bus_wdata;
      if (out_we)   out_q   <= out_d;
    end
  end

  // Read path
  always_comb begin
    win_view  = ((out_q & dir_q) | (pin_sync & ~dir_q)) & pin_mask;
    bus_rdata = '0;
    if (win_hit) begin
      bus_rdata = win_view;
    end else if (cfg_hit) begin
      case (sel)
        SEL_DIR:   bus_rdata = dir_q;
        SEL_SENSE: bus_rdata = sense_q;
        SEL_BOTH:  bus_rdata = both_q;
        SEL_EVENT: bus_rdata = event_q;
        SEL_EN:    bus_rdata = en_q;
        SEL_RAW:   bus_rdata = raw_st;
        SEL_MASK:  bus_rdata = raw_st & en_q;
        default:   bus_rdata = '0;
      endcase
    end
  end

  // R2
  dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(1 << REGION_BIT)) |=> (dir_q == $past(bus_wdata)));

  // R4
  input_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_q ^ $past(out_q)) & ~$past(dir_q)) == '0);

  // R3
  unmasked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && win_hit) |=> (((out_q ^ $past(out_q)) & ~$past(pin_mask)) == '0));

endmodule

// File: rtl/gpio8_irq.sv
module gpio8_irq
  import gpio8_pkg::*;
#(
  parameter int NP     = NPINS,
  parameter int SYNC_N = SYNC_STAGES,
  parameter int ADDR_W = NP + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [NP-1:0]     bus_wdata,
  output logic [NP-1:0]     bus_rdata,
  input  logic [NP-1:0]     pin_in,
  output logic [NP-1:0]     pin_out,
  output logic [NP-1:0]     pin_oe,
  output logic              irq_out
);

  logic          rst_core_n;
  logic [NP-1:0] pin_sync;
  logic [NP-1:0] raw_st;
  logic [NP-1:0] dir_q;
  logic [NP-1:0] sense_q;
  logic [NP-1:0] both_q;
  logic [NP-1:0] event_q;
  logic [NP-1:0] en_q;
  logic [NP-1:0] out_q;
  logic [NP-1:0] clr_pulse;

  gpio8_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  gpio8_in_sync #(.WIDTH(NP), .STAGES(SYNC_N)) u_sync (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .async_in (pin_in),
    .sync_out (pin_sync)
  );

  gpio8_regs #(.NP(NP), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .pin_sync  (pin_sync),
    .raw_st    (raw_st),
    .dir_q     (dir_q),
    .sense_q   (sense_q),
    .both_q    (both_q),
    .event_q   (event_q),
    .en_q      (en_q),
    .out_q     (out_q),
    .clr_pulse (clr_pulse),
    .bus_rdata (bus_rdata)
  );

  for (genvar i = 0; i < NP; i++) begin : g_pin
    gpio8_irq_pin u_det (
      .clk       (clk),
      .rst_n     (rst_core_n),
      .smp       (pin_sync[i]),
      .sense_lvl (sense_q[i]),
      .both_edge (both_q[i]),
      .event_pol (event_q[i]),
      .clr       (clr_pulse[i]),
      .raw       (raw_st[i])
    );
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign irq_out = |(raw_st & en_q);

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (en_q == '0) |-> !irq_out);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_core_n |-> (pin_oe == '0 && !irq_out));

endmodule

// File: tb/sim_gpio8_irq.sv
module sim_gpio8_irq;

  logic        clk;
  logic        rst_n;
  logic [10:0] bus_addr;
  logic        bus_wr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [7:0]  pin_in;
  logic [7:0]  pin_out;
  logic [7:0]  pin_oe;
  logic        irq_out;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  gpio8_irq u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq_out   (irq_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  localparam logic [10:0] A_DIR = 11'h400, A_SNS = 11'h404, A_BTH = 11'h408,
                          A_EVT = 11'h40C, A_EN  = 11'h410, A_RAW = 11'h414,
                          A_MIS = 11'h418, A_CLR = 11'h41C;

  // {write, addr, wdata, expected read}
  localparam int NV = 20;
  localparam logic [27:0] VEC [NV] = '{
    {1'b1, 11'h400, 8'hF0, 8'h00},
    {1'b0, 11'h400, 8'h00, 8'hF0},
    {1'b1, 11'h3FC, 8'hAA, 8'h00},
    {1'b0, 11'h3FC, 8'h00, 8'hA5},
    {1'b0, 11'h0C0, 8'h00, 8'h20},
    {1'b1, 11'h03C, 8'hFF, 8'h00},
    {1'b0, 11'h3FC, 8'h00, 8'hA5},
    {1'b1, 11'h300, 8'h40, 8'h00},
    {1'b0, 11'h3FC, 8'h00, 8'h65},
    {1'b0, 11'h004, 8'h00, 8'h01},
    {1'b0, 11'h008, 8'h00, 8'h00},
    {1'b1, 11'h404, 8'h12, 8'h00},
    {1'b0, 11'h404, 8'h00, 8'h12},
    {1'b1, 11'h408, 8'h34, 8'h00},
    {1'b0, 11'h408, 8'h00, 8'h34},
    {1'b1, 11'h40C, 8'h56, 8'h00},
    {1'b0, 11'h40C, 8'h00, 8'h56},
    {1'b1, 11'h410, 8'h00, 8'h00},
    {1'b0, 11'h410, 8'h00, 8'h00},
    {1'b0, 11'h41C, 8'h00, 8'h00}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic bwr(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic brd(input logic [10:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_up();
  end

  initial begin
    logic [7:0] rd;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; pin_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset state
    brd(A_DIR, rd); chk("R1 dir", rd, 8'h00);
    brd(A_SNS, rd); chk("R1 sense", rd, 8'h00);
    brd(A_EN,  rd); chk("R1 enable", rd, 8'h00);
    brd(A_RAW, rd); chk("R1 raw", rd, 8'h00);
    chk("R1 pin_oe", pin_oe, 8'h00);
    chk("R1 pin_out", pin_out, 8'h00);
    chk("R1 irq", {7'd0, irq_out}, 8'h00);

    // Vector table: R2 R3 R4 R5 R11
    pin_in = 8'h05;
    settle();
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][27]) begin
        bwr(VEC[i][26:16], VEC[i][15:8]);
      end else begin
        brd(VEC[i][26:16], rd);
        chk($sformatf("R3/R5/R11 vector %0d", i), rd, VEC[i][7:0]);
      end
    end
    chk("R2 pin_oe", pin_oe, 8'hF0);
    chk("R3 pin_out", pin_out, 8'h60);
    bwr(A_SNS, 8'h00); bwr(A_BTH, 8'h00); bwr(A_EVT, 8'h00);

    // R4 rewrite after turning to output
    bwr(11'h004, 8'h01);
    chk("R4 input write no effect", pin_out, 8'h60);
    bwr(A_DIR, 8'hF1);
    chk("R4 old value after dir change", pin_out, 8'h60);
    bwr(11'h004, 8'h01);
    chk("R4 rewrite drives", pin_out, 8'h61);
    bwr(A_DIR, 8'h00);

    // R6 level sensing
    pin_in = 8'h00;
    settle();
    bwr(A_CLR, 8'hFF);
    bwr(A_SNS, 8'h01); bwr(A_EVT, 8'h01); bwr(A_EN, 8'h01);
    brd(A_RAW, rd); chk("R6 high level idle", rd, 8'h00);
    pin_in = 8'h01; settle();
    brd(A_RAW, rd); chk("R6 high level raw", rd, 8'h01);
    chk("R6 irq on level", {7'd0, irq_out}, 8'h01);
    bwr(A_CLR, 8'h01);
    brd(A_RAW, rd); chk("R6 clear ignored on level", rd, 8'h01);
    pin_in = 8'h00; settle();
    brd(A_RAW, rd); chk("R6 level follows input", rd, 8'h00);
    chk("R6 irq drops", {7'd0, irq_out}, 8'h00);
    bwr(A_EVT, 8'h00);
    brd(A_RAW, rd); chk("R6 low level raw", rd, 8'h01);
    bwr(A_SNS, 8'h00); bwr(A_EN, 8'h00);
    brd(A_RAW, rd); chk("R6 back to edge idle", rd, 8'h00);

    // R7 single edge
    bwr(A_EVT, 8'h04);
    pin_in = 8'h04; settle();
    brd(A_RAW, rd); chk("R7 rising latched", rd, 8'h04);
    pin_in = 8'h00; settle();
    brd(A_RAW, rd); chk("R7 stays latched", rd, 8'h04);
    bwr(A_CLR, 8'h04);
    brd(A_RAW, rd); chk("R7 cleared", rd, 8'h00);
    pin_in = 8'h04; settle();
    bwr(A_CLR, 8'h04);
    pin_in = 8'h00; settle();
    brd(A_RAW, rd); chk("R7 falling ignored when rising", rd, 8'h00);
    pin_in = 8'h08; settle();
    brd(A_RAW, rd); chk("R7 rising ignored when falling", rd, 8'h00);
    pin_in = 8'h00; settle();
    brd(A_RAW, rd); chk("R7 falling latched", rd, 8'h08);
    bwr(A_CLR, 8'h08);

    // R8 both edges, event bit left 0
    bwr(A_EVT, 8'h00); bwr(A_BTH, 8'h10);
    pin_in = 8'h10; settle();
    brd(A_RAW, rd); chk("R8 rising with both", rd, 8'h10);
    bwr(A_CLR, 8'h10);
    pin_in = 8'h00; settle();
    brd(A_RAW, rd); chk("R8 falling with both", rd, 8'h10);

    // R9 enable gating
    brd(A_MIS, rd); chk("R9 masked off", rd, 8'h00);
    chk("R9 irq off", {7'd0, irq_out}, 8'h00);
    bwr(A_EN, 8'h10);
    brd(A_MIS, rd); chk("R9 masked on", rd, 8'h10);
    chk("R9 irq on", {7'd0, irq_out}, 8'h01);
    bwr(A_EN, 8'h00);

    // R10 zero write, coincident edge and clear
    bwr(A_CLR, 8'h00);
    brd(A_RAW, rd); chk("R10 zero clear", rd, 8'h10);
    bwr(A_CLR, 8'h10);
    pin_in = 8'h10; settle();
    brd(A_RAW, rd); chk("R10 set before race", rd, 8'h10);
    @(negedge clk);
    pin_in = 8'h00;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    bus_addr = A_CLR; bus_wdata = 8'h10; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    settle();
    brd(A_RAW, rd); chk("R10 edge wins over clear", rd, 8'h10);
    bwr(A_CLR, 8'h10);
    brd(A_RAW, rd); chk("R10 plain clear", rd, 8'h00);

    finish_up();
  end

endmodule